// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block sits on the controller side of an asynchronous DRAM. It moves the memory into its low-power self-refresh state when the system asks for standby, and brings it back out when the system asks to wake. It drives the active-low row and column strobes from the system clock. Every analog timing minimum is turned into a clock-cycle count at elaboration, using a clock-period parameter and rounding up.

The system raises `sleep_req_i` to request standby. The sequencer first lowers the column strobe and then the row strobe, which is column-before-row ordering. It keeps both low for the minimum self-refresh pulse and only then raises `sleep_ack_o`. When the request drops, both strobes return high together. The row strobe then stays high for the precharge time of the selected speed grade before the sequence completes.

`burst_mode_i` is sampled when a request is accepted. When it is set, a full-array burst of column-before-row refresh pulses runs immediately before entry and again immediately after exit. When it is clear, refresh is assumed to be distributed elsewhere, and entry and exit stand alone. `busy_o` marks every cycle in which a sequence is in progress.

Top module: `dram_sref_seq`

## Requirements
- R1: After reset, and while asynchronous reset is held, `ras_no` and `cas_no` are 1 and `sleep_ack_o` and `busy_o` are 0. With no request, the block stays in that state.
- R2: Every falling edge of `ras_no` is preceded by at least one clock cycle with `cas_no` already 0. `cas_no` is never 1 while `ras_no` is 0.
- R3: `sleep_ack_o` first rises only after both strobes have been low for at least SREF_CYC = ceil(SREF_MIN_NS*1000/CLK_PERIOD_PS) full cycles. `sleep_ack_o` is 1 only while both strobes are 0.
- R4: If the request drops before the self-refresh minimum has elapsed, the low period is not shortened. Exit waits until the minimum is met.
- R5: One cycle after `sleep_req_i` drops while `sleep_ack_o` is 1, `sleep_ack_o` is 0 and both strobes are 1. The two strobes rise in the same cycle.
- R6: After exit, `ras_no` stays 1 for at least PRE_CYC cycles before any further fall and before `busy_o` drops. PRE_CYC is ceil(110 ns) for SPEED_GRADE 0 and ceil(125 ns) for SPEED_GRADE 1, in clock cycles.
- R7: With `burst_mode_i`=1, BURST_COUNT refresh pulses run before entry and BURST_COUNT after exit, each with `ras_no` low for BURST_LOW_CYC cycles. One sequence therefore gives 2*BURST_COUNT+1 falls of `ras_no`.
- R8: With `burst_mode_i`=0, one sequence gives exactly one fall of `ras_no`.
- R9: The gap from the end of the pre-entry burst to entry, and the span from exit to the end of the post-exit burst, each stay under 2 ms in cycles.
- R10: `busy_o` is 1 from the cycle after a request is accepted until the sequence has completed. It is 1 whenever `sleep_ack_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | High requests standby; low requests wake |
| burst_mode_i | input | 1 | 1: wrap entry and exit in refresh bursts; sampled when a request is accepted |
| ras_no | output | 1 | Row strobe to the DRAM, active low |
| cas_no | output | 1 | Column strobe to the DRAM, active low |
| sleep_ack_o | output | 1 | DRAM is in self-refresh and its minimum pulse has been met |
| busy_o | output | 1 | A sequence is in progress |

## Verification
The assertions assume that `sleep_req_i` changes only between clock edges. They also assume that `burst_mode_i` is stable at the cycle a request is accepted, and that the timing parameters give counts of at least one cycle. The bench drives every input one time unit after the rising edge, sets the mode before raising the request, and uses small parameter values so that whole bursts fit in a short run. Requests are dropped at several points: before the hold ends, on the first acknowledge cycle, and after long dwells. This covers both the early-wake and the normal exit paths.

// File: rtl/dram_sref_pkg.sv
`timescale 1ns/1ps
package dram_sref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_BURST, ST_CBR_SETUP, ST_SR_HOLD,
    ST_SR, ST_EXIT_PRE, ST_POST_BURST, ST_DONE
  } sref_state_e;

  typedef enum logic [1:0] {
    BP_IDLE, BP_LEAD, BP_LOW, BP_HIGH
  } burst_phase_e;

  // ceil(t_ns * 1000 / clk_ps)
  function automatic int unsigned ns_to_cycles(input longint unsigned t_ns,
                                               input longint unsigned clk_ps);
    longint unsigned c;
    c = (t_ns * 64'd1000 + clk_ps - 64'd1) / clk_ps;
    return c[31:0];
  endfunction

endpackage

// File: rtl/sref_timer.sv
`timescale 1ns/1ps
module sref_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_load_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/sref_burst_engine.sv
`timescale 1ns/1ps
module sref_burst_engine
  import dram_sref_pkg::*;
#(
  parameter int unsigned BURST_COUNT    = 2048,
  parameter int unsigned CAS_LEAD_CYC   = 2,
  parameter int unsigned BURST_LOW_CYC  = 8,
  parameter int unsigned BURST_HIGH_CYC = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ras_no,
  output logic cas_no,
  output logic done_o
);
  localparam int unsigned MAX_A  = (CAS_LEAD_CYC > BURST_LOW_CYC) ? CAS_LEAD_CYC : BURST_LOW_CYC;
  localparam int unsigned MAX_PH = (MAX_A > BURST_HIGH_CYC) ? MAX_A : BURST_HIGH_CYC;
  localparam int unsigned CW     = $clog2(MAX_PH + 1);
  localparam int unsigned PW     = $clog2(BURST_COUNT + 1);

  burst_phase_e  phase_q, phase_d;
  logic [CW-1:0] ph_cnt_q, ph_cnt_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic          last_pulse;

  assign last_pulse = (pulse_q == PW'(BURST_COUNT - 1));

  always_comb begin
    phase_d  = phase_q;
    ph_cnt_d = ph_cnt_q;
    pulse_d  = pulse_q;
    unique case (phase_q)
      BP_IDLE: if (start_i) begin
        phase_d  = BP_LEAD;
        ph_cnt_d = CW'(CAS_LEAD_CYC - 1);
        pulse_d  = '0;
      end
      BP_LEAD: begin
        if (ph_cnt_q == '0) begin
          phase_d  = BP_LOW;
          ph_cnt_d = CW'(BURST_LOW_CYC - 1);
        end else ph_cnt_d = ph_cnt_q - 1'b1;
      end
      BP_LOW: begin
        if (ph_cnt_q == '0) begin
          phase_d  = BP_HIGH;
          ph_cnt_d = CW'(BURST_HIGH_CYC - 1);
        end else ph_cnt_d = ph_cnt_q - 1'b1;
      end
      BP_HIGH: begin
        if (ph_cnt_q == '0) begin
          if (last_pulse) phase_d = BP_IDLE;
          else begin
            phase_d  = BP_LEAD;
            ph_cnt_d = CW'(CAS_LEAD_CYC - 1);
            pulse_d  = pulse_q + 1'b1;
          end
        end else ph_cnt_d = ph_cnt_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= BP_IDLE;
      ph_cnt_q <= '0;
      pulse_q  <= '0;
    end else begin
      phase_q  <= phase_d;
      ph_cnt_q <= ph_cnt_d;
      pulse_q  <= pulse_d;
    end
  end

  assign done_o = (phase_q == BP_HIGH) && (ph_cnt_q == '0) && last_pulse;
  assign ras_no = (phase_q != BP_LOW);
  assign cas_no = !((phase_q == BP_LEAD) || (phase_q == BP_LOW));

  assert_pulse_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q < PW'(BURST_COUNT));
  assert_start_only_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> phase_q == BP_IDLE);
  assert_cas_leads_ras_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> $past(!cas_no));

endmodule

// File: rtl/dram_sref_seq.sv
`timescale 1ns/1ps
module dram_sref_seq
  import dram_sref_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS  = 8000,
  parameter int unsigned SPEED_GRADE    = 0,
  parameter int unsigned SREF_MIN_NS    = 100000,
  parameter int unsigned PRE_FAST_NS    = 110,
  parameter int unsigned PRE_SLOW_NS    = 125,
  parameter int unsigned DEADLINE_NS    = 2000000,
  parameter int unsigned BURST_COUNT    = 2048,
  parameter int unsigned CAS_LEAD_CYC   = 2,
  parameter int unsigned BURST_LOW_CYC  = 8,
  parameter int unsigned BURST_HIGH_CYC = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic burst_mode_i,
  output logic ras_no,
  output logic cas_no,
  output logic sleep_ack_o,
  output logic busy_o
);
  localparam int unsigned SREF_CYC     = ns_to_cycles(SREF_MIN_NS, CLK_PERIOD_PS);
  localparam int unsigned PRE_NS       = (SPEED_GRADE == 0) ? PRE_FAST_NS : PRE_SLOW_NS;
  localparam int unsigned PRE_CYC      = ns_to_cycles(PRE_NS, CLK_PERIOD_PS);
  localparam int unsigned DEADLINE_CYC = ns_to_cycles(DEADLINE_NS, CLK_PERIOD_PS);
  localparam int unsigned MAX_A        = (SREF_CYC > PRE_CYC) ? SREF_CYC : PRE_CYC;
  localparam int unsigned MAX_T        = (MAX_A > CAS_LEAD_CYC) ? MAX_A : CAS_LEAD_CYC;
  localparam int unsigned TW           = $clog2(MAX_T + 1);

  sref_state_e   state_q, state_d;
  logic          mode_q;
  logic          tm_load, tm_zero;
  logic [TW-1:0] tm_val;
  logic          bst_start, bst_done, bst_ras_n, bst_cas_n;

  sref_timer #(.W(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tm_load),
    .load_val_i (tm_val),
    .zero_o     (tm_zero)
  );

  sref_burst_engine #(
    .BURST_COUNT    (BURST_COUNT),
    .CAS_LEAD_CYC   (CAS_LEAD_CYC),
    .BURST_LOW_CYC  (BURST_LOW_CYC),
    .BURST_HIGH_CYC (BURST_HIGH_CYC)
  ) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (bst_start),
    .ras_no  (bst_ras_n),
    .cas_no  (bst_cas_n),
    .done_o  (bst_done)
  );

  always_comb begin
    state_d   = state_q;
    tm_load   = 1'b0;
    tm_val    = '0;
    bst_start = 1'b0;
    case (state_q)
      ST_IDLE: if (sleep_req_i) begin
        if (burst_mode_i) begin
          state_d   = ST_PRE_BURST;
          bst_start = 1'b1;
        end else begin
          state_d = ST_CBR_SETUP;
          tm_load = 1'b1;
          tm_val  = TW'(CAS_LEAD_CYC - 1);
        end
      end
      ST_PRE_BURST: if (bst_done) begin
        state_d = ST_CBR_SETUP;
        tm_load = 1'b1;
        tm_val  = TW'(CAS_LEAD_CYC - 1);
      end
      ST_CBR_SETUP: if (tm_zero) begin
        state_d = ST_SR_HOLD;
        tm_load = 1'b1;
        tm_val  = TW'(SREF_CYC - 1);
      end
      ST_SR_HOLD: if (tm_zero) state_d = ST_SR;  // wake held off until minimum met
      ST_SR: if (!sleep_req_i) begin
        state_d = ST_EXIT_PRE;
        tm_load = 1'b1;
        tm_val  = TW'(PRE_CYC - 1);
      end
      ST_EXIT_PRE: if (tm_zero) begin
        if (mode_q) begin
          state_d   = ST_POST_BURST;
          bst_start = 1'b1;
        end else state_d = ST_DONE;
      end
      ST_POST_BURST: if (bst_done) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && sleep_req_i) mode_q <= burst_mode_i;
    end
  end

  always_comb begin
    ras_no = 1'b1;
    cas_no = 1'b1;
    case (state_q)
      ST_PRE_BURST, ST_POST_BURST: begin
        ras_no = bst_ras_n;
        cas_no = bst_cas_n;
      end
      ST_CBR_SETUP: cas_no = 1'b0;
      ST_SR_HOLD, ST_SR: begin
        ras_no = 1'b0;
        cas_no = 1'b0;
      end
      default: ;
    endcase
  end

  assign sleep_ack_o = (state_q == ST_SR);
  assign busy_o      = (state_q != ST_IDLE);

  // checker counters
  logic [31:0] low_cnt_q, hi_cnt_q, gap_pre_q, gap_post_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q  <= '0;
      hi_cnt_q   <= '0;
      gap_pre_q  <= '0;
      gap_post_q <= '0;
    end else begin
      low_cnt_q  <= (!ras_no && !cas_no) ? ((low_cnt_q == '1) ? low_cnt_q : low_cnt_q + 1) : '0;
      hi_cnt_q   <= ras_no ? ((hi_cnt_q == '1) ? hi_cnt_q : hi_cnt_q + 1) : '0;
      gap_pre_q  <= (state_q == ST_CBR_SETUP && mode_q) ? gap_pre_q + 1 : '0;
      gap_post_q <= (state_q == ST_EXIT_PRE || state_q == ST_POST_BURST) ? gap_post_q + 1 : '0;
    end
  end

  assert_idle_strobes_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ras_no && cas_no && !sleep_ack_o));
  assert_cas_not_high_alone_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ras_no && cas_no));
  assert_cbr_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> $past(!cas_no));
  assert_ack_strobes_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_ack_o |-> (!ras_no && !cas_no));
  assert_ack_after_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_ack_o) |-> low_cnt_q >= 32'(SREF_CYC));
  assert_ack_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_ack_o && !sleep_req_i) |=> (!sleep_ack_o && ras_no && cas_no));
  assert_precharge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXIT_PRE && state_d != ST_EXIT_PRE) |-> (hi_cnt_q + 32'd1) >= 32'(PRE_CYC));
  assert_pre_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_pre_q < 32'(DEADLINE_CYC));
  assert_post_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_post_q < 32'(DEADLINE_CYC));
  assert_busy_with_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_ack_o |-> busy_o);

endmodule

// File: tb/sim_dram_sref_seq.sv
`timescale 1ns/1ps
module sim_dram_sref_seq;
  localparam int CLK_PS   = 8000;
  localparam int SREF_NS  = 400;
  localparam int BC       = 8;
  localparam int BLOW     = 3;
  localparam int BHIGH    = 2;
  localparam int LEAD     = 1;
  localparam int SREF_CYC = (SREF_NS * 1000 + CLK_PS - 1) / CLK_PS;  // 50
  localparam int PRE_CYC  = (125 * 1000 + CLK_PS - 1) / CLK_PS;      // 16 (grade 1)
  localparam longint DEADLINE_CYC = 64'd2000000000 / CLK_PS;

  // {burst_mode, dwell_after_ack, expected_ras_falls}
  localparam logic [24:0] VEC [5] = '{
    {1'b1, 8'd5,  16'd17},
    {1'b0, 8'd5,  16'd1},
    {1'b0, 8'd0,  16'd1},
    {1'b1, 8'd20, 16'd17},
    {1'b0, 8'd40, 16'd1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0;
  logic mode = 1'b0;
  logic ras_n, cas_n, ack, busy;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dram_sref_seq #(
    .CLK_PERIOD_PS (CLK_PS),
    .SPEED_GRADE   (1),
    .SREF_MIN_NS   (SREF_NS),
    .BURST_COUNT   (BC),
    .CAS_LEAD_CYC  (LEAD),
    .BURST_LOW_CYC (BLOW),
    .BURST_HIGH_CYC(BHIGH)
  ) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .sleep_req_i  (req),
    .burst_mode_i (mode),
    .ras_no       (ras_n),
    .cas_no       (cas_n),
    .sleep_ack_o  (ack),
    .busy_o       (busy)
  );

  // strobe monitor, sampled on the falling edge
  logic clr = 1'b0;
  logic p_ras, p_cas, p_ack, p_busy;
  int falls, cbr_viol, split, low_run, high_run, ack_rises, ack_low_run;
  int ack_bad, last_short, pre_len;
  logic meas_pre;

  always @(negedge clk) begin
    if (clr || !rst_ni) begin
      falls = 0; cbr_viol = 0; split = 0; low_run = 0; high_run = 0;
      ack_rises = 0; ack_low_run = 0; ack_bad = 0; last_short = 0;
      pre_len = 0; meas_pre = 1'b0;
    end else begin
      if (!ras_n && p_ras) begin
        falls++;
        if (p_cas) cbr_viol++;
        if (meas_pre) begin pre_len = high_run; meas_pre = 1'b0; end
      end
      if (!ras_n && cas_n) split++;
      if (ras_n && !p_ras) begin
        if (!cas_n) split++;
        if (low_run < SREF_CYC) last_short = low_run;
        else meas_pre = 1'b1;
      end
      if (!ras_n) low_run = p_ras ? 1 : low_run + 1;
      if (ras_n) high_run = p_ras ? high_run + 1 : 1;
      if (ack && !p_ack) begin ack_rises++; ack_low_run = low_run; end
      if (ack && (ras_n || cas_n)) ack_bad++;
      if (!busy && p_busy && meas_pre) begin pre_len = high_run; meas_pre = 1'b0; end
    end
    p_ras = ras_n; p_cas = cas_n; p_ack = ack; p_busy = busy;
  end

  task automatic check(input bit ok, input string req_id, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req_id, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_stats();
    clr = 1'b1;
    tick();
    clr = 1'b0;
  endtask

  task automatic wait_ack(output bit got);
    got = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      tick();
      if (ack) begin got = 1'b1; break; end
    end
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    for (int i = 0; i < 5000; i++) begin
      if (!busy) break;
      tick();
      cyc++;
    end
  endtask

  task automatic run_seq(input bit burst, input int dwell, input int exp_falls);
    bit got;
    int cyc;
    string rq;
    rq = burst ? "R7" : "R8";
    clear_stats();
    mode = burst;
    req = 1'b1;
    wait_ack(got);
    check(got, "R3 ack seen", int'(got), 1);
    check(busy == 1'b1, "R10 busy during sleep", int'(busy), 1);
    for (int i = 0; i < dwell; i++) tick();
    req = 1'b0;
    tick();
    check(!ack && ras_n && cas_n, "R5 exit strobes", int'({ack, ras_n, cas_n}), 3);
    check(ack_low_run >= SREF_CYC + 1, "R3 low before ack", ack_low_run, SREF_CYC + 1);
    wait_idle(cyc);
    check(longint'(cyc) < DEADLINE_CYC, "R9 exit span", cyc, int'(DEADLINE_CYC));
    tick();
    check(falls == exp_falls, rq, falls, exp_falls);
    if (burst) check(last_short == BLOW, "R7 burst low width", last_short, BLOW);
    check(cbr_viol == 0 && split == 0, "R2 strobe order", cbr_viol + split, 0);
    check(pre_len >= PRE_CYC, "R6 precharge", pre_len, PRE_CYC);
    check(ack_bad == 0 && ack_rises == 1, "R3 ack window", ack_bad * 100 + ack_rises, 1);
    check(!busy && ras_n && cas_n && !ack, "R1 idle after sequence", int'({busy, ras_n, cas_n, ack}), 6);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R10 watchdog act=%0d exp=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    bit got;
    int cyc;
    #1;
    check(ras_n && cas_n && !ack && !busy, "R1 in reset", int'({ras_n, cas_n, ack, busy}), 12);
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (5) tick();
    check(ras_n && cas_n && !ack && !busy, "R1 idle no request", int'({ras_n, cas_n, ack, busy}), 12);

    for (int v = 0; v < 5; v++)
      run_seq(VEC[v][24], int'(VEC[v][23:16]), int'(VEC[v][15:0]));

    // R4: wake requested a few cycles into the hold
    clear_stats();
    mode = 1'b0;
    req = 1'b1;
    for (int i = 0; i < 100; i++) begin
      tick();
      if (!ras_n) break;
    end
    repeat (3) tick();
    req = 1'b0;
    wait_idle(cyc);
    tick();
    check(ack_low_run >= SREF_CYC + 1, "R4 early wake hold", ack_low_run, SREF_CYC + 1);
    check(falls == 1, "R4 single entry", falls, 1);
    check(pre_len >= PRE_CYC, "R6 precharge after early wake", pre_len, PRE_CYC);

    // R1: asynchronous reset in the middle of the hold
    clear_stats();
    req = 1'b1;
    repeat (10) tick();
    check(!ras_n && !cas_n, "R2 in hold", int'({ras_n, cas_n}), 0);
    rst_ni = 1'b0;
    #1;
    check(ras_n && cas_n && !ack && !busy, "R1 reset mid hold", int'({ras_n, cas_n, ack, busy}), 12);
    req = 1'b0;
    tick();
    rst_ni = 1'b1;
    repeat (3) tick();

    // R10: busy then completes a fresh sequence after reset
    clear_stats();
    mode = 1'b1;
    req = 1'b1;
    tick();
    tick();
    check(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
    wait_ack(got);
    check(got, "R7 ack after burst", int'(got), 1);
    req = 1'b0;
    wait_idle(cyc);
    tick();
    check(falls == 2 * BC + 1, "R7 falls after reset", falls, 2 * BC + 1);

    finish_run();
  end

endmodule